// File: doc/BRIEF.md
# Multi-Channel Completion Interrupt Register Bank

This block is the shared interrupt and control register bank of a multi-channel DMA engine. The channels are grouped in pairs, one pair per instance. Within pair k, the receive channel is channel 2k and the transmit channel is channel 2k+1. Each channel signals the end of a transfer with a one-cycle completion pulse. That pulse sets the channel's bit in a raw status register. Software reads the status, clears it by writing ones, and selects through an enable register which channels may raise the single level interrupt output. A read-only pending view returns status AND enable, so a handler can see in one read which enabled channels need service.

A plain 32-bit register port reaches four registers:

| Register | Offset | Access |
|---|---|---|
| Address control | 0x34 | read/write |
| Raw status | 0x080000 | write-one-to-clear |
| Pending | 0x080004 | read-only |
| Enable | 0x080008 | read/write |

Bit 0 of the address-control register selects 32-bit addressing for the data movers. The data movers, descriptor handling and bus mastering sit outside this block. Their only link to it is the completion pulses.

Top module: `dma_irq_regbank`

## Requirements
- R1: During and after reset, the status, enable and address-control registers are zero, `irq` is low, `addr32_mode` is low and `reg_rdata` is zero.
- R2: The registers are decoded at these exact byte offsets: status 0x080000, pending 0x080004, enable 0x080008, address control 0x034. Any other address reads zero, and a write to it changes nothing.
- R3: A pulse on `rx_done[k]` sets status bit 2k, and a pulse on `tx_done[k]` sets status bit 2k+1. The bit is set at the clock edge where the pulse is sampled.
- R4: A write to the status offset clears every status bit whose `reg_wdata` bit is 1 and leaves every bit whose `reg_wdata` bit is 0 unchanged. Writing 0xFFFFFFFF clears all status bits.
- R5: If a completion pulse and a write-one-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R6: The pending offset reads status AND enable. Writes to it are ignored, and reading it changes no state.
- R7: `irq` is high exactly when status AND enable is non-zero. It follows the register contents in the cycle after the edge that changed them.
- R8: Writing 0 to the enable register drops `irq` and leaves the status bits intact. Enabling again a channel whose status bit is still set raises `irq` again.
- R9: Bit 0 of the address-control register is read/write and drives `addr32_mode`. Its other bits read zero.
- R10: In the status, pending and enable registers, bits at or above 2*NUM_PAIRS read zero and ignore writes.
- R11: A read takes one cycle. `reg_rdata` is loaded at the edge where `reg_rd` is sampled, with the values the registers held before that edge. Otherwise `reg_rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_done | input | NUM_PAIRS | Completion pulses of the receive channels (channel 2k) |
| tx_done | input | NUM_PAIRS | Completion pulses of the transmit channels (channel 2k+1) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while any enabled status bit is set |
| addr32_mode | output | 1 | 32-bit addressing select |

## Verification
The bench builds the block with NUM_PAIRS=3, which gives six channels. Bits 6 to 31 of status, pending and enable must therefore read zero even after all-ones writes, and this makes R10 observable. The default of four pairs would fill only one byte and hide the edge between implemented and absent bits. The bench uses the default ADDR_W of 20 bits, which is enough to decode the high global offsets next to the low address-control offset. A behavioural model is compared with the outputs on every clock. It runs through directed cases (set-versus-clear collisions, read-before-update, unmapped addresses) and then a pseudo-random run.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam logic [31:0] OFF_ACR  = 32'h0000_0034;
  localparam logic [31:0] OFF_STAT = 32'h0008_0000;
  localparam logic [31:0] OFF_PEND = 32'h0008_0004;
  localparam logic [31:0] OFF_EN   = 32'h0008_0008;

  typedef struct packed {
    logic stat;
    logic pend;
    logic en;
    logic acr;
  } regsel_t;
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
  import dmairq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] addr,
  output regsel_t           sel
);
  always_comb begin
    sel.stat = (addr == ADDR_W'(OFF_STAT));
    sel.pend = (addr == ADDR_W'(OFF_PEND));
    sel.en   = (addr == ADDR_W'(OFF_EN));
    sel.acr  = (addr == ADDR_W'(OFF_ACR));
  end

  // R2: an address selects at most one register
  always_comb begin
    a_r2_onehot_sel: assert ($onehot0({sel.stat, sel.pend, sel.en, sel.acr}));
  end
endmodule

// File: rtl/dmairq_status.sv
module dmairq_status #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] status
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          status[i] <= 1'b0;
      else if (set_vec[i]) status[i] <= 1'b1;
      else if (clr_vec[i]) status[i] <= 1'b0;
    end
  end

  // R5: a completion always lands, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R4: a clear without a competing set empties the bit
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

  // R4: no set and no clear keeps every bit
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && clr_vec == '0) |=> $stable(status));
endmodule

// File: rtl/dma_irq_regbank.sv
module dma_irq_regbank
  import dmairq_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PAIRS-1:0] rx_done,
  input  logic [NUM_PAIRS-1:0] tx_done,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq,
  output logic                 addr32_mode
);
  localparam int NUM_CH = 2 * NUM_PAIRS;

  regsel_t           sel;
  logic [NUM_CH-1:0] set_vec;
  logic [NUM_CH-1:0] clr_vec;
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] enable_q;
  logic [NUM_CH-1:0] pending;
  logic              acr_q;
  logic [31:0]       rd_mux;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  dmairq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (reg_addr),
    .sel  (sel)
  );

  // receive channel of pair k is bit 2k, transmit channel is bit 2k+1
  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    assign set_vec[2*k]   = rx_done[k];
    assign set_vec[2*k+1] = tx_done[k];
  end

  assign clr_vec = (reg_wr && sel.stat) ? reg_wdata[NUM_CH-1:0] : '0;

  dmairq_status #(.NUM_CH(NUM_CH)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status  (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      acr_q    <= 1'b0;
    end else if (reg_wr) begin
      if (sel.en)  enable_q <= reg_wdata[NUM_CH-1:0];
      if (sel.acr) acr_q    <= reg_wdata[0];
    end
  end

  assign pending     = status & enable_q;
  assign irq         = |pending;
  assign addr32_mode = acr_q;

  always_comb begin
    rd_mux = '0;
    if (sel.stat) rd_mux[NUM_CH-1:0] = status;
    if (sel.pend) rd_mux[NUM_CH-1:0] = pending;
    if (sel.en)   rd_mux[NUM_CH-1:0] = enable_q;
    if (sel.acr)  rd_mux[0]          = acr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R10: nothing above the channel count ever reaches the read port
  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata >> NUM_CH) == 32'h0));

  // R8: clearing the enable register removes the interrupt
  a_r8_mask_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel.en && reg_wdata[NUM_CH-1:0] == '0) |=> !irq);

  // R2: an unmapped read returns zero
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sel == '0) |=> (reg_rdata == 32'h0));

  // R11: without a read strobe the read data holds
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/test_dma_irq_regbank.sv
module test_dma_irq_regbank;
  localparam int NP  = 3;
  localparam int NCH = 2 * NP;
  localparam logic [31:0] MASK = (32'h1 << NCH) - 32'h1;
  localparam logic [19:0] A_ST = 20'h80000, A_PD = 20'h80004,
                          A_EN = 20'h80008, A_AC = 20'h00034;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] rx_done = '0, tx_done = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [19:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq, addr32_mode;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_stat = 0, m_en = 0, m_rd = 0;
  logic        m_acr = 0;

  always #5 clk = ~clk;

  dma_irq_regbank #(.NUM_PAIRS(NP), .ADDR_W(20)) i_dma_irq_regbank (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .addr32_mode(addr32_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [19:0] a);
    if (a == A_ST) return m_stat;
    if (a == A_PD) return m_stat & m_en;
    if (a == A_EN) return m_en;
    if (a == A_AC) return {31'h0, m_acr};
    return 32'h0;
  endfunction

  task automatic step(input logic [NP-1:0] rx, input logic [NP-1:0] tx,
                      input logic wr, input logic rd, input logic [19:0] a,
                      input logic [31:0] d, input string req);
    logic [31:0] setv, clrv;
    rx_done = rx; tx_done = tx; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (rd) m_rd = m_read(a);
    setv = 0;
    for (int k = 0; k < NP; k++) begin
      setv[2*k]   = rx[k];
      setv[2*k+1] = tx[k];
    end
    clrv = (wr && a == A_ST) ? (d & MASK) : 32'h0;
    m_stat = (m_stat & ~clrv) | setv;
    if (wr && a == A_EN) m_en = d & MASK;
    if (wr && a == A_AC) m_acr = d[0];
    @(negedge clk);
    rx_done = '0; tx_done = '0; reg_wr = 0; reg_rd = 0;
    chk({req, " rdata"}, reg_rdata, m_rd);
    chk("R7 irq", {31'h0, irq}, {31'h0, |(m_stat & m_en)});
    chk("R9 addr32_mode", {31'h0, addr32_mode}, {31'h0, m_acr});
  endtask

  task automatic rd(input logic [19:0] a, input string req);
    step('0, '0, 0, 1, a, 32'h0, req);
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d, input string req);
    step('0, '0, 1, 0, a, d, req);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    chk("R1 reset addr32", {31'h0, addr32_mode}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(A_ST, "R1"); rd(A_EN, "R1"); rd(A_AC, "R1");
    // address control
    wr(A_AC, 32'h1, "R9"); rd(A_AC, "R9");
    wr(A_AC, 32'hFFFF_FFFE, "R9"); rd(A_AC, "R9");
    wr(A_AC, 32'hFFFF_FFFF, "R9"); rd(A_AC, "R9");
    // channel mapping: rx pair 0 -> bit0, tx pair 2 -> bit5
    step(3'b001, 3'b000, 0, 0, 0, 0, "R3");
    step(3'b000, 3'b100, 0, 0, 0, 0, "R3");
    rd(A_ST, "R3"); rd(A_PD, "R6");
    // enable with bits above the channel count
    wr(A_EN, 32'hFFFF_FFFF, "R10"); rd(A_EN, "R10"); rd(A_PD, "R6");
    // pending is read only
    wr(A_PD, 32'h0, "R6"); rd(A_PD, "R6"); rd(A_ST, "R6");
    // masking keeps status, unmasking brings the interrupt back
    wr(A_EN, 32'h0, "R8"); rd(A_ST, "R8"); rd(A_PD, "R8");
    wr(A_EN, 32'h20, "R8"); rd(A_PD, "R8");
    // write-one-to-clear, zeros leave bits alone
    wr(A_ST, 32'h1, "R4"); rd(A_ST, "R4");
    // clear and set together on bit 5
    step(3'b000, 3'b100, 1, 0, A_ST, 32'h20, "R5"); rd(A_ST, "R5");
    // read sees the value before the edge
    step(3'b010, 3'b000, 0, 1, A_ST, 0, "R11"); rd(A_ST, "R11");
    wr(A_ST, 32'hFFFF_FFFF, "R4"); rd(A_ST, "R4");
    // unmapped addresses
    wr(20'h00040, 32'hFFFF_FFFF, "R2"); rd(20'h00040, "R2");
    wr(20'h8000C, 32'hFFFF_FFFF, "R2"); rd(20'h8000C, "R2");
    rd(A_EN, "R2"); rd(A_AC, "R2");
    // pseudo-random mix
    lf = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sel;
      logic [19:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      sel = lf[1:0];
      a = (sel == 0) ? A_ST : (sel == 1) ? A_PD : (sel == 2) ? A_EN : A_AC;
      step(lf[4:2] & {3{lf[11]}}, lf[7:5] & {3{lf[12]}}, lf[8] & lf[9],
           lf[10], a, {lf, lf[15:8], lf[7:0]}, "R6 R7 R11 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule